// File: doc/BRIEF.md
# Indexed Register and Video-Memory Access Window

This block is the register front end of a display controller. It decodes byte-addressed accesses of one, two or four bytes into a small 32-bit register space. A register can be written or read at any byte offset. The byte lanes outside the access keep their contents on a write and read back as zero on a read. Each register applies its own mask of writable bits. A range of the space is a read-only mirror of configuration words, fetched through a simple read port. A status word always reports a full command queue of 64 free slots.

Software reaches everything indirectly through a pair of registers: a 32-bit selector at byte 0x000 and a four-byte data window at 0x004..0x007. If the top bit of the selector is clear, an access to the window lands on the register at selector plus the window byte offset. If the top bit is set, the access goes to video memory at the selector's lower 31 bits, in little-endian order. Memory accesses that would run past the end of memory are dropped. Memory accesses stall on the memory's ready signal. Every other access completes in the cycle it is presented.

A strap input selects the smaller device variant. On that variant only the lower half of the eight scratch words is present.

Top module: `ixwin_top`

## Requirements
- R1: After reset the selector and all scratch and general registers read 0.
- R2: A write of size S (1, 2 or 4 bytes) at byte offset O replaces bits [8*O +: 8*S] of the 32-bit register, clipped at bit 31, and leaves the other bits unchanged. A 4-byte write at offset 0 replaces the whole word.
- R3: A read of size S at offset O returns register bits [8*O +: 8*S], zero-extended to 32 bits.
- R4: The four general registers at 0x080, 0x084, 0x088 and 0x08C only store the bits of their write masks: 0x07FF07FF, 0x0FFF0FFF, 0xC7FFFFFF and 0x00FFFFFF. The selector and the scratch words store all 32 bits.
- R5: With selector bit 31 clear, a window access at 0x004+k acts on the register byte address selector[13:0]+k.
- R6: With selector bit 31 set, a window access reads or writes S bytes of video memory starting at selector[30:0], with the lowest address in bits 7:0. It completes in the cycle vmem_ready_i is high.
- R7: A memory access whose address is above the memory size minus S issues no memory request. Its write is dropped, its read returns 0, and it completes at once.
- R8: Byte addresses 0xF00..0xFFF read the word returned on cfg_rdata_i for word index address[7:2], with lane extraction as in R3. Writes there change nothing.
- R9: The word at 0x040 always reads 64, and writes to it are ignored.
- R10: Scratch words 0..7 sit at 0x010+4*i. While narrow_scratch_i is high, words 4..7 read 0 and ignore writes, and the stored contents are preserved.
- R11: A window access whose target register address falls in 0x000..0x007 does nothing, and its read returns 0.
- R12: Every access other than an in-range memory access completes in the cycle it is presented, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| narrow_scratch_i | input | 1 | Strap for the small variant (4 scratch words) |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Access completes this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW (14) | Byte address |
| req_size_i | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_rdata_o | output | 32 | Read data, right-aligned, valid while request and ready |
| vmem_req_o | output | 1 | Video-memory request |
| vmem_we_o | output | 1 | Video-memory write |
| vmem_addr_o | output | VMAW (20) | Video-memory byte address |
| vmem_size_o | output | 3 | Video-memory access size in bytes |
| vmem_wdata_o | output | 32 | Video-memory write data, little-endian |
| vmem_rdata_i | input | 32 | Video-memory read data, little-endian |
| vmem_ready_i | input | 1 | Video-memory access completes |
| cfg_addr_o | output | 6 | Configuration mirror word index |
| cfg_rdata_i | input | 32 | Configuration mirror word |

## Verification
The assertions take it that req_size_i holds only 1, 2 or 4. They also take it that a request, once presented, holds its address, size and data until ready. The memory-bound check further relies on the memory reporting ready only while a request is open. The bench's driver task keeps each request stable from just after a falling edge until it sees ready. It only ever issues the three legal sizes. Its memory model raises ready for a single cycle, two cycles after a request appears.

// File: rtl/ixwin_pkg.sv
`timescale 1ns/1ps
package ixwin_pkg;
  // word indices of the register space
  localparam int unsigned IDX_W  = 0;
  localparam int unsigned WIN_W  = 1;
  localparam int unsigned SCR_W  = 4;
  localparam int unsigned FIFO_W = 16;
  localparam int unsigned GEN_W  = 32;
  localparam int unsigned CFG_LO = 32'hF00;
  localparam int unsigned CFG_HI = 32'hFFF;
  localparam logic [31:0] FIFO_FREE = 32'd64;

  typedef enum logic [1:0] {RT_NONE, RT_REG, RT_MEM} route_e;

  function automatic logic [31:0] size_mask(logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] gen_wmask(int unsigned i);
    case (i)
      0:       return 32'h07FF_07FF;
      1:       return 32'h0FFF_0FFF;
      2:       return 32'hC7FF_FFFF;
      3:       return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] bits, logic [31:0] lane);
    return (old & ~lane) | (bits & lane);
  endfunction
endpackage

// File: rtl/ixwin_route.sv
`timescale 1ns/1ps
module ixwin_route import ixwin_pkg::*; #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] addr_i,
  input  logic          idx_mem_i,
  input  logic [AW-1:0] idx_off_i,
  output route_e        route_o,
  output logic [AW-1:0] eff_o
);
  logic win;
  assign win = (addr_i[AW-1:2] == (AW-2)'(WIN_W));

  always_comb begin
    route_o = RT_REG;
    eff_o   = addr_i;
    if (win) begin
      if (idx_mem_i) begin
        route_o = RT_MEM;
        eff_o   = '0;
      end else begin
        eff_o = idx_off_i + AW'(addr_i[1:0]);
        // window into selector/window itself: no-op, no recursion
        if (eff_o[AW-1:3] == '0) route_o = RT_NONE;
      end
    end
  end
endmodule

// File: rtl/ixwin_vmem.sv
`timescale 1ns/1ps
module ixwin_vmem import ixwin_pkg::*; #(
  parameter int VMEM_BYTES = 1 << 20,
  localparam int VMAW = $clog2(VMEM_BYTES)
) (
  input  logic            act_i,
  input  logic            we_i,
  input  logic [30:0]     maddr_i,
  input  logic [2:0]      size_i,
  input  logic [31:0]     wdata_i,
  output logic            vmem_req_o,
  output logic            vmem_we_o,
  output logic [VMAW-1:0] vmem_addr_o,
  output logic [2:0]      vmem_size_o,
  output logic [31:0]     vmem_wdata_o,
  input  logic [31:0]     vmem_rdata_i,
  output logic            in_rng_o,
  output logic [31:0]     rdata_o
);
  // addr + size <= limit  <=>  addr <= limit - size, without underflow
  assign in_rng_o     = (33'(maddr_i) + 33'(size_i)) <= 33'(VMEM_BYTES);
  assign vmem_req_o   = act_i && in_rng_o;
  assign vmem_we_o    = we_i;
  assign vmem_addr_o  = maddr_i[VMAW-1:0];
  assign vmem_size_o  = size_i;
  assign vmem_wdata_o = wdata_i & size_mask(size_i);
  assign rdata_o      = in_rng_o ? (vmem_rdata_i & size_mask(size_i)) : '0;
endmodule

// File: rtl/ixwin_regs.sv
`timescale 1ns/1ps
module ixwin_regs import ixwin_pkg::*; #(
  parameter int AW          = 14,
  parameter int NSCR        = 8,
  parameter int NSCR_NARROW = 4,
  parameter int NGEN        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          narrow_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wbits_i,
  input  logic [31:0]   lane_i,
  output logic [5:0]    cfg_addr_o,
  input  logic [31:0]   cfg_rdata_i,
  output logic [31:0]   rword_o,
  output logic [31:0]   idx_o
);
  int unsigned wa, ba;
  assign ba = 32'(addr_i);
  assign wa = ba >> 2;
  assign cfg_addr_o = addr_i[7:2];

  logic [31:0] idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (wr_i && wa == IDX_W) idx_q <= lane_merge(idx_q, wbits_i, lane_i);
  end
  assign idx_o = idx_q;

  logic [31:0] scr_rd [NSCR];
  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    localparam bit FIXED = (g < NSCR_NARROW);
    logic        live;
    logic [31:0] q;
    assign live = FIXED || !narrow_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && live && wa == SCR_W + unsigned'(g)) q <= lane_merge(q, wbits_i, lane_i);
    end
    assign scr_rd[g] = live ? q : '0;
  end

  logic [31:0] gen_rd [NGEN];
  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    localparam logic [31:0] WMASK = gen_wmask(unsigned'(g));
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && wa == GEN_W + unsigned'(g)) q <= lane_merge(q, wbits_i, lane_i) & WMASK;
    end
    assign gen_rd[g] = q;
  end

  always_comb begin
    rword_o = '0;
    if (wa == IDX_W)  rword_o = idx_q;
    if (wa == FIFO_W) rword_o = FIFO_FREE;
    for (int i = 0; i < NSCR; i++)
      if (wa == SCR_W + unsigned'(i)) rword_o = scr_rd[i];
    for (int i = 0; i < NGEN; i++)
      if (wa == GEN_W + unsigned'(i)) rword_o = gen_rd[i];
    if (ba >= CFG_LO && ba <= CFG_HI) rword_o = cfg_rdata_i;
  end
endmodule

// File: rtl/ixwin_top.sv
`timescale 1ns/1ps
module ixwin_top import ixwin_pkg::*; #(
  parameter int AW          = 14,
  parameter int VMEM_BYTES  = 1 << 20,
  parameter int NSCR        = 8,
  parameter int NSCR_NARROW = 4,
  parameter int NGEN        = 4,
  localparam int VMAW = $clog2(VMEM_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            narrow_scratch_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [2:0]      req_size_i,
  input  logic [31:0]     req_wdata_i,
  output logic [31:0]     rsp_rdata_o,
  output logic            vmem_req_o,
  output logic            vmem_we_o,
  output logic [VMAW-1:0] vmem_addr_o,
  output logic [2:0]      vmem_size_o,
  output logic [31:0]     vmem_wdata_o,
  input  logic [31:0]     vmem_rdata_i,
  input  logic            vmem_ready_i,
  output logic [5:0]      cfg_addr_o,
  input  logic [31:0]     cfg_rdata_i
);
  logic [31:0]   idx_q;
  route_e        route;
  logic [AW-1:0] eff;

  ixwin_route #(.AW(AW)) u_route (
    .addr_i    (req_addr_i),
    .idx_mem_i (idx_q[31]),
    .idx_off_i (idx_q[AW-1:0]),
    .route_o   (route),
    .eff_o     (eff)
  );

  logic [4:0]  sh;
  logic [31:0] smask, lane, wbits, rword;
  assign sh    = {eff[1:0], 3'b000};
  assign smask = size_mask(req_size_i);
  assign lane  = smask << sh;
  assign wbits = req_wdata_i << sh;

  logic        mem_act, mem_inrng;
  logic [31:0] mem_rdata;
  assign mem_act = req_valid_i && (route == RT_MEM);

  ixwin_vmem #(.VMEM_BYTES(VMEM_BYTES)) u_vmem (
    .act_i        (mem_act),
    .we_i         (req_write_i),
    .maddr_i      (idx_q[30:0]),
    .size_i       (req_size_i),
    .wdata_i      (req_wdata_i),
    .vmem_req_o   (vmem_req_o),
    .vmem_we_o    (vmem_we_o),
    .vmem_addr_o  (vmem_addr_o),
    .vmem_size_o  (vmem_size_o),
    .vmem_wdata_o (vmem_wdata_o),
    .vmem_rdata_i (vmem_rdata_i),
    .in_rng_o     (mem_inrng),
    .rdata_o      (mem_rdata)
  );

  ixwin_regs #(
    .AW(AW), .NSCR(NSCR), .NSCR_NARROW(NSCR_NARROW), .NGEN(NGEN)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .narrow_i    (narrow_scratch_i),
    .wr_i        (req_valid_i && req_write_i && route == RT_REG),
    .addr_i      (eff),
    .wbits_i     (wbits),
    .lane_i      (lane),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_rdata_i (cfg_rdata_i),
    .rword_o     (rword),
    .idx_o       (idx_q)
  );

  assign req_ready_o = (route == RT_MEM && mem_inrng) ? vmem_ready_i : 1'b1;

  always_comb begin
    case (route)
      RT_REG:  rsp_rdata_o = (rword >> sh) & smask;
      RT_MEM:  rsp_rdata_o = mem_rdata;
      default: rsp_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ixwin_chk.sv
`timescale 1ns/1ps
module ixwin_chk import ixwin_pkg::*; #(
  parameter int AW         = 14,
  parameter int VMEM_BYTES = 1 << 20,
  localparam int VMAW = $clog2(VMEM_BYTES)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            narrow_scratch_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            req_write_i,
  input logic [AW-1:0]   req_addr_i,
  input logic [2:0]      req_size_i,
  input logic [31:0]     rsp_rdata_o,
  input logic            vmem_req_o,
  input logic [VMAW-1:0] vmem_addr_o,
  input logic [2:0]      vmem_size_o,
  input logic [31:0]     idx_q
);
  logic win;
  assign win = (req_addr_i[AW-1:2] == (AW-2)'(WIN_W));

  p_single_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !(win && idx_q[31]) |-> req_ready_o);

  p_mem_in_bounds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vmem_req_o |-> (33'(vmem_addr_o) + 33'(vmem_size_o)) <= 33'(VMEM_BYTES));

  p_mem_via_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vmem_req_o |-> req_valid_i && win && idx_q[31]);

  p_fifo_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_addr_i == AW'(32'h40) && req_size_i == 3'd4
    |-> rsp_rdata_o == 32'd64);

  p_narrow_hidden_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && narrow_scratch_i &&
    req_addr_i >= AW'(32'h20) && req_addr_i < AW'(32'h30)
    |-> rsp_rdata_o == 32'd0);

  p_self_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && win && !idx_q[31] && idx_q[AW-1:0] == '0
    |=> idx_q == $past(idx_q));
endmodule

bind ixwin_top ixwin_chk #(.AW(AW), .VMEM_BYTES(VMEM_BYTES)) i_chk (.*);

// File: tb/test_ixwin_top.sv
`timescale 1ns/1ps
module test_ixwin_top;
  localparam int MB = 4096;
  logic clk = 1'b0, rst_n = 1'b0, narrow = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [13:0] req_addr = '0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_wdata = '0, rdata;
  logic vmem_req, vmem_we, vrdy;
  logic [11:0] vmem_addr;
  logic [2:0] vmem_size;
  logic [31:0] vmem_wdata, vmem_rdata, cfg_rdata;
  logic [5:0] cfg_addr;
  logic [1:0] cnt;
  logic [7:0] mem [MB];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ixwin_top #(.VMEM_BYTES(MB)) i_ixwin_top (
    .clk_i(clk), .rst_ni(rst_n), .narrow_scratch_i(narrow),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rdata), .vmem_req_o(vmem_req), .vmem_we_o(vmem_we),
    .vmem_addr_o(vmem_addr), .vmem_size_o(vmem_size), .vmem_wdata_o(vmem_wdata),
    .vmem_rdata_i(vmem_rdata), .vmem_ready_i(vrdy),
    .cfg_addr_o(cfg_addr), .cfg_rdata_i(cfg_rdata)
  );

  // configuration mirror model
  assign cfg_rdata = 32'hC0DE_0000 | 32'(cfg_addr);

  // video memory model: ready two cycles after request
  always_comb begin
    vmem_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (int'(vmem_addr) + k < MB) vmem_rdata[8*k +: 8] = mem[int'(vmem_addr) + k];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; vrdy <= 1'b0;
      for (int k = 0; k < MB; k++) mem[k] <= 8'h00;
    end else if (vmem_req && vrdy) begin
      cnt <= '0; vrdy <= 1'b0;
      if (vmem_we)
        for (int k = 0; k < int'(vmem_size); k++) mem[int'(vmem_addr) + k] <= vmem_wdata[8*k +: 8];
    end else if (vmem_req) begin
      cnt <= cnt + 2'd1;
      vrdy <= (cnt == 2'd1);
    end
  end

  typedef struct { bit chk; logic [31:0] exp; string tag; } exp_t;
  exp_t exp_q[$];

  // monitor: compares completed reads against the scoreboard
  always @(negedge clk) begin
    #3;
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        n_bad++; $display("FAIL scoreboard underrun rdata=%h exp=none", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.chk) begin
          n_chk++;
          if (rdata !== e.exp) begin
            n_bad++; $display("FAIL %s rdata=%h exp=%h", e.tag, rdata, e.exp);
          end
        end
      end
    end
  end

  task automatic acc(input bit wr, input logic [13:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input logic [31:0] ex, input bit imm,
                     input string tag);
    exp_t e;
    e.chk = !wr; e.exp = ex; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #2;
    if (imm) begin
      n_chk++;
      if (!req_ready) begin
        n_bad++; $display("FAIL R12 %s ready=%0b exp=1", tag, req_ready);
      end
    end
    while (!req_ready) begin @(negedge clk); #3; end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [13:0] a, input logic [2:0] sz, input logic [31:0] d, input string tag);
    acc(1'b1, a, sz, d, '0, 1'b1, tag);
  endtask
  task automatic rd(input logic [13:0] a, input logic [2:0] sz, input logic [31:0] ex, input string tag);
    acc(1'b0, a, sz, '0, ex, 1'b1, tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(14'h000, 3'd4, 32'h0, "R1 selector");
    rd(14'h010, 3'd4, 32'h0, "R1 scratch0");
    rd(14'h080, 3'd4, 32'h0, "R1 gen0");

    // R2 lane insertion, R3 lane extraction
    wr(14'h010, 3'd4, 32'h1122_3344, "R2 full");
    rd(14'h010, 3'd4, 32'h1122_3344, "R2 full word");
    wr(14'h011, 3'd1, 32'hFFFF_FFAB, "R2 byte");
    rd(14'h010, 3'd4, 32'h1122_AB44, "R2 byte merge");
    wr(14'h012, 3'd2, 32'h0000_BEEF, "R2 half");
    rd(14'h010, 3'd4, 32'hBEEF_AB44, "R2 half merge");
    rd(14'h013, 3'd1, 32'h0000_00BE, "R3 byte off3");
    rd(14'h011, 3'd2, 32'h0000_EFAB, "R3 half off1");

    // R4 write masks
    wr(14'h080, 3'd4, 32'hFFFF_FFFF, "R4");
    rd(14'h080, 3'd4, 32'h07FF_07FF, "R4 gen0 mask");
    wr(14'h088, 3'd4, 32'hFFFF_FFFF, "R4");
    rd(14'h088, 3'd4, 32'hC7FF_FFFF, "R4 gen2 mask");

    // R5 register path through the window
    wr(14'h000, 3'd4, 32'h0000_0080, "R5 sel");
    wr(14'h004, 3'd4, 32'h1234_5678, "R5 win write");
    rd(14'h080, 3'd4, 32'h0234_0678, "R5 gen0 via window");
    wr(14'h000, 3'd4, 32'h0000_0084, "R5 sel");
    wr(14'h005, 3'd1, 32'h0000_00FF, "R5 win byte");
    rd(14'h084, 3'd4, 32'h0000_0F00, "R5 R4 gen1 via window byte");
    wr(14'h000, 3'd4, 32'h0000_0010, "R5 sel");
    rd(14'h006, 3'd1, 32'h0000_00EF, "R5 win read offs");

    // R6 video memory path
    wr(14'h000, 3'd4, 32'h8000_0100, "R6 sel");
    acc(1'b1, 14'h004, 3'd4, 32'hCAFE_F00D, '0, 1'b0, "R6 mem write");
    acc(1'b0, 14'h004, 3'd4, '0, 32'hCAFE_F00D, 1'b0, "R6 mem word");
    acc(1'b0, 14'h004, 3'd1, '0, 32'h0000_000D, 1'b0, "R6 mem byte");
    wr(14'h000, 3'd4, 32'h8000_0102, "R6 sel");
    acc(1'b0, 14'h004, 3'd2, '0, 32'h0000_CAFE, 1'b0, "R6 mem half");

    // R7 bounds
    wr(14'h000, 3'd4, 32'h8000_0FFE, "R7 sel");
    wr(14'h004, 3'd4, 32'h1111_2222, "R7 oob write");
    rd(14'h004, 3'd4, 32'h0, "R7 oob read");
    acc(1'b0, 14'h004, 3'd2, '0, 32'h0, 1'b0, "R7 dropped write");
    acc(1'b1, 14'h004, 3'd2, 32'h0000_5A5A, '0, 1'b0, "R7 edge write");
    wr(14'h000, 3'd4, 32'h8000_0FFC, "R7 sel");
    acc(1'b0, 14'h004, 3'd4, '0, 32'h5A5A_0000, 1'b0, "R7 edge read");

    // R8 configuration mirror
    rd(14'hF08, 3'd4, 32'hC0DE_0002, "R8 word");
    rd(14'hF0A, 3'd2, 32'h0000_C0DE, "R8 half");
    wr(14'hF08, 3'd4, 32'h0, "R8 write");
    rd(14'hF08, 3'd4, 32'hC0DE_0002, "R8 after write");

    // R9 queue status
    rd(14'h040, 3'd4, 32'd64, "R9");
    wr(14'h040, 3'd4, 32'h0, "R9 write");
    rd(14'h040, 3'd4, 32'd64, "R9 after write");
    rd(14'h040, 3'd1, 32'h40, "R9 byte");

    // R10 narrow scratch strap
    wr(14'h024, 3'd4, 32'h5555_AAAA, "R10 wide write");
    narrow = 1'b1;
    rd(14'h024, 3'd4, 32'h0, "R10 hidden");
    wr(14'h024, 3'd4, 32'h9999_9999, "R10 narrow write");
    wr(14'h01C, 3'd4, 32'h3333_3333, "R10 low write");
    rd(14'h01C, 3'd4, 32'h3333_3333, "R10 low word");
    narrow = 1'b0;
    rd(14'h024, 3'd4, 32'h5555_AAAA, "R10 preserved");

    // R11 window aimed at itself
    wr(14'h000, 3'd4, 32'h0, "R11 sel");
    wr(14'h004, 3'd4, 32'hDEAD_BEEF, "R11 self write");
    rd(14'h000, 3'd4, 32'h0, "R11 selector kept");
    wr(14'h000, 3'd4, 32'h0000_0004, "R11 sel");
    rd(14'h004, 3'd4, 32'h0, "R11 self read");

    // R12 unmapped
    rd(14'h300, 3'd4, 32'h0, "R12 unmapped");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++; $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule